// File: doc/BRIEF.md
# Indirect PHY Register Access Engine

This block is a hardware master for a bank of 16-bit PHY registers that sit outside the memory map. The PHY is reached only through one 32-bit control word driven by the engine and one 32-bit status word returned by the PHY. The status word carries an acknowledge flag. Each transfer of an address, a data value or a command is a four-step exchange:

1. Raise a strobe.
2. Wait for the acknowledge flag to go high.
3. Remove the strobe.
4. Wait for the acknowledge flag to go low.

A client offers one request at a time on a valid/ready port. A request is a read or write flag, a 16-bit register address and 16-bit write data. The engine runs the whole sequence against the PHY and then pulses a response that carries read data and an error flag. Every wait for the acknowledge flag samples it once every `POLL_GAP` clock cycles. A wait gives up after `MAX_POLLS` samples, and the engine then aborts the transaction with an error.

Top module: `phy_acc_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `phy_ctrl` is all zeros and `rsp_valid` is 0.
- R2: Control word layout: bits 15:0 carry an address or data value, bit 16 is the address capture strobe, bit 17 the data capture strobe, bit 18 the write strobe and bit 19 the read strobe. At most one strobe is set at any time.
- R3: Every transaction opens with an address phase. The control word steps through address alone, then address plus bit 16 (held until acknowledge reads 1), then address alone again (held until acknowledge reads 0).
- R4: A write continues with a data phase. The control word steps through data alone, then data plus bit 17 (until acknowledge reads 1), then data alone (until acknowledge reads 0).
- R5: A write then commits. The control word is bit 18 alone (until acknowledge reads 1), then data alone (until acknowledge reads 0), then all zeros. The response carries error 0, and the PHY register at the address then holds the data.
- R6: A read follows the address phase with bit 19 alone in the control word, held until acknowledge reads 1. At that sample the engine captures status bits 15:0 and clears the control word to zero. Once acknowledge reads 0, it responds with the captured data and error 0.
- R7: The acknowledge flag is status bit 16. Each wait samples it every `POLL_GAP` cycles, `MAX_POLLS` times at most. An acknowledge that arrives before the last sample completes the wait.
- R8: When a wait sees no acknowledge after its last sample, the control word returns to zero and the response carries error 1 and read data 0. For a stall in the first wait, the response appears `1 + POLL_GAP*MAX_POLLS` cycles after acceptance.
- R9: Only one transaction is in flight. `req_ready` is low from acceptance until the cycle that carries the response, and request inputs have no effect during that time.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Acknowledge timeout |
| phy_ctrl | output | 32 | Control word to the PHY port |
| phy_stat | input | 32 | Status word from the PHY port |

## Verification
Two events can fall in the same cycle: a response is delivered and a new request is accepted, because the engine becomes ready in the very cycle it pulses `rsp_valid`. The bench provokes this by holding `req_valid` high with a second request throughout the first one. It judges the overlap in three ways: the second request must be accepted only in the cycle that shows the first response, that response's data and error must be unaffected, and the second transaction must then complete in full. The polling boundary is probed with a PHY model whose acknowledge arrives just before the last sample, and then just after it.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 16;
    localparam int STB_W   = 4;
    localparam int ACK_POS = 16;

    localparam logic [STB_W-1:0] STB_NONE = 4'b0000;
    localparam logic [STB_W-1:0] STB_CAPA = 4'b0001;
    localparam logic [STB_W-1:0] STB_CAPD = 4'b0010;
    localparam logic [STB_W-1:0] STB_WR   = 4'b0100;
    localparam logic [STB_W-1:0] STB_RD   = 4'b1000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SET,
        ST_ADDR_CAP,
        ST_ADDR_REL,
        ST_DATA_SET,
        ST_DATA_CAP,
        ST_DATA_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_RD_STB,
        ST_RD_REL
    } seq_state_e;

    typedef struct packed {
        logic               write;
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] wdata;
    } phy_req_t;

    function automatic logic [WORD_W-1:0] ctrl_word(logic [FIELD_W-1:0] field,
                                                    logic [STB_W-1:0]   stb);
        return {{(WORD_W-FIELD_W-STB_W){1'b0}}, stb, field};
    endfunction

    function automatic logic is_wait(seq_state_e s);
        return (s == ST_ADDR_CAP) || (s == ST_ADDR_REL) || (s == ST_DATA_CAP) ||
               (s == ST_DATA_REL) || (s == ST_WR_STB)   || (s == ST_WR_REL)   ||
               (s == ST_RD_STB)   || (s == ST_RD_REL);
    endfunction

    function automatic logic ack_goal(seq_state_e s);
        return (s == ST_ADDR_CAP) || (s == ST_DATA_CAP) ||
               (s == ST_WR_STB)   || (s == ST_RD_STB);
    endfunction

endpackage

// File: rtl/phy_acc_poll.sv
module phy_acc_poll #(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic target,
    input  logic ack,
    output logic hit,
    output logic expire
);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] poll_cnt;
    logic          sample;

    assign sample = active && (gap_cnt == GW'(POLL_GAP - 1));
    assign hit    = sample && (ack == target);
    assign expire = sample && (ack != target) && (poll_cnt == PW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || hit || expire) begin
            gap_cnt  <= '0;
            poll_cnt <= '0;
        end else if (sample) begin
            gap_cnt  <= '0;
            poll_cnt <= poll_cnt + 1'b1;
        end else begin
            gap_cnt  <= gap_cnt + 1'b1;
        end
    end

    // R7: a wait never takes more samples than allowed
    a_r7_poll_bound: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < PW'(MAX_POLLS));

    // R7: counters restart when the engine leaves a wait
    a_r7_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !active |=> (poll_cnt == '0));

endmodule

// File: rtl/phy_acc_seq.sv
module phy_acc_seq
    import phy_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  phy_req_t           req,
    output logic               rsp_valid,
    output logic [FIELD_W-1:0] rsp_rdata,
    output logic               rsp_err,
    output logic [WORD_W-1:0]  phy_ctrl,
    input  logic [FIELD_W-1:0] stat_data,
    output logic               wait_active,
    output logic               wait_target,
    input  logic               ack_hit,
    input  logic               ack_expire
);
    seq_state_e state;
    phy_req_t   req_q;

    assign req_ready   = (state == ST_IDLE);
    assign wait_active = is_wait(state);
    assign wait_target = ack_goal(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            phy_ctrl  <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (ack_expire) begin
                phy_ctrl  <= '0;
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                rsp_rdata <= '0;
                state     <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (req_valid) begin
                        req_q    <= req;
                        phy_ctrl <= ctrl_word(req.addr, STB_NONE);
                        state    <= ST_ADDR_SET;
                    end
                    ST_ADDR_SET: begin
                        phy_ctrl <= ctrl_word(req_q.addr, STB_CAPA);
                        state    <= ST_ADDR_CAP;
                    end
                    ST_ADDR_CAP: if (ack_hit) begin
                        phy_ctrl <= ctrl_word(req_q.addr, STB_NONE);
                        state    <= ST_ADDR_REL;
                    end
                    ST_ADDR_REL: if (ack_hit) begin
                        if (req_q.write) begin
                            phy_ctrl <= ctrl_word(req_q.wdata, STB_NONE);
                            state    <= ST_DATA_SET;
                        end else begin
                            phy_ctrl <= ctrl_word('0, STB_RD);
                            state    <= ST_RD_STB;
                        end
                    end
                    ST_DATA_SET: begin
                        phy_ctrl <= ctrl_word(req_q.wdata, STB_CAPD);
                        state    <= ST_DATA_CAP;
                    end
                    ST_DATA_CAP: if (ack_hit) begin
                        phy_ctrl <= ctrl_word(req_q.wdata, STB_NONE);
                        state    <= ST_DATA_REL;
                    end
                    ST_DATA_REL: if (ack_hit) begin
                        phy_ctrl <= ctrl_word('0, STB_WR);
                        state    <= ST_WR_STB;
                    end
                    ST_WR_STB: if (ack_hit) begin
                        phy_ctrl <= ctrl_word(req_q.wdata, STB_NONE);
                        state    <= ST_WR_REL;
                    end
                    ST_WR_REL: if (ack_hit) begin
                        phy_ctrl  <= '0;
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_rdata <= '0;
                        state     <= ST_IDLE;
                    end
                    ST_RD_STB: if (ack_hit) begin
                        rsp_rdata <= stat_data;
                        phy_ctrl  <= '0;
                        state     <= ST_RD_REL;
                    end
                    ST_RD_REL: if (ack_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        state     <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: never more than one strobe in the control word
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phy_ctrl[19:16]));

    // R5: the write strobe travels with an empty field
    a_r5_wr_alone: assert property (@(posedge clk) disable iff (rst)
        phy_ctrl[18] |-> (phy_ctrl[15:0] == '0));

    // R6: the read strobe travels with an empty field
    a_r6_rd_alone: assert property (@(posedge clk) disable iff (rst)
        phy_ctrl[19] |-> (phy_ctrl[15:0] == '0));

    // R8: an error response leaves the control word cleared
    a_r8_err_clears: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (phy_ctrl == '0));

    // R9: acceptance closes the request port
    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10: the response is a single-cycle pulse
    a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/phy_acc_engine.sv
module phy_acc_engine
    import phy_acc_pkg::*;
#(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic [31:0] phy_ctrl,
    input  logic [31:0] phy_stat
);
    phy_req_t req;
    logic     wait_active, wait_target, ack_hit, ack_expire;
    logic     unused_stat_hi;

    assign req            = '{write: req_write, addr: req_addr, wdata: req_wdata};
    assign unused_stat_hi = ^phy_stat[WORD_W-1:ACK_POS+1];

    phy_acc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req         (req),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .phy_ctrl    (phy_ctrl),
        .stat_data   (phy_stat[FIELD_W-1:0]),
        .wait_active (wait_active),
        .wait_target (wait_target),
        .ack_hit     (ack_hit),
        .ack_expire  (ack_expire)
    );

    phy_acc_poll #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_poll (
        .clk    (clk),
        .rst    (rst),
        .active (wait_active),
        .target (wait_target),
        .ack    (phy_stat[ACK_POS]),
        .hit    (ack_hit),
        .expire (ack_expire)
    );

endmodule

// File: tb/phy_acc_engine_tb.sv
module phy_acc_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int MAXP       = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] phy_ctrl;
    logic [31:0] phy_stat;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_acc_engine #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // PHY model: register file plus delayed acknowledge
    int          up_dly = 3;
    int          dn_dly = 2;
    int          m_cnt;
    logic        m_ack;
    logic [15:0] m_addr, m_data;
    logic [15:0] m_mem [16];

    assign phy_stat = {15'b0, m_ack, m_mem[m_addr[3:0]]};

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  <= 0;
            m_ack  <= 1'b0;
            m_addr <= '0;
            m_data <= '0;
            for (int i = 0; i < 16; i++) m_mem[i] <= '0;
        end else if ((|phy_ctrl[19:16]) == m_ack) begin
            m_cnt <= 0;
        end else if (m_cnt >= ((m_ack ? dn_dly : up_dly) - 1)) begin
            m_cnt <= 0;
            m_ack <= ~m_ack;
            if (!m_ack && phy_ctrl[16]) m_addr <= phy_ctrl[15:0];
            if (!m_ack && phy_ctrl[17]) m_data <= phy_ctrl[15:0];
            if (!m_ack && phy_ctrl[18]) m_mem[m_addr[3:0]] <= m_data;
        end else begin
            m_cnt <= m_cnt + 1;
        end
    end

    // control word change log
    logic [31:0] clog [16];
    int          clog_n = 0;
    logic [31:0] clast  = '0;
    always @(negedge clk) begin
        if (phy_ctrl !== clast) begin
            if (clog_n < 16) clog[clog_n] = phy_ctrl;
            clog_n = clog_n + 1;
            clast  = phy_ctrl;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // issue one request, return response and latency in cycles after acceptance
    task automatic run_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           output logic [15:0] rd, output logic er, output int lat);
        bit busy_ok = 1;
        @(negedge clk);
        clog_n    = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 16'hFFFF; req_wdata = 16'hFFFF; req_write = ~wr;
        lat = 0;
        while (!rsp_valid) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata; er = rsp_err;
        check(busy_ok, "R9 ready low while busy", 32'(busy_ok), 1);
        check(req_ready, "R9 ready back in response cycle", 32'(req_ready), 1);
        @(negedge clk);
        check(!rsp_valid, "R10 response lasts one cycle", 32'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        check(phy_ctrl == '0, "R1 control word zero", phy_ctrl, 0);
        check(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] rd; logic er; int lat;
        logic [31:0] exp [9];
        run_req(1'b1, a, d, rd, er, lat);
        exp = '{{16'h0, a}, {16'h1, a}, {16'h0, a},
                {16'h0, d}, {16'h2, d}, {16'h0, d},
                32'h0004_0000, {16'h0, d}, 32'h0};
        check(clog_n == 9, "R3 R4 R5 write step count", clog_n, 9);
        for (int i = 0; i < 9; i++)
            check(clog[i] == exp[i], (i < 3) ? "R3 address phase" : (i < 6) ? "R4 data phase" : "R5 commit",
                  clog[i], exp[i]);
        check(er == 1'b0, "R5 write ok", 32'(er), 0);
        check(rd == 16'h0, "R5 write rdata zero", 32'(rd), 0);
        check(m_mem[a[3:0]] == d, "R5 PHY register written", m_mem[a[3:0]], d);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] rd; logic er; int lat;
        logic [31:0] exp [5];
        run_req(1'b0, a, 16'h0, rd, er, lat);
        exp = '{{16'h0, a}, {16'h1, a}, {16'h0, a}, 32'h0008_0000, 32'h0};
        check(clog_n == 5, "R6 read step count", clog_n, 5);
        for (int i = 0; i < 5; i++)
            check(clog[i] == exp[i], (i < 3) ? "R3 address phase" : "R6 read strobe", clog[i], exp[i]);
        check(er == 1'b0, "R6 read ok", 32'(er), 0);
        check(rd == d, "R6 read data", 32'(rd), d);
    endtask

    task automatic t_slow_ack();
        up_dly = 38;
        t_write(16'h0003, 16'h5A5A);
        t_read(16'h0003, 16'h5A5A);
        up_dly = 3;
    endtask

    task automatic t_timeout(input bit wr);
        logic [15:0] rd; logic er; int lat;
        up_dly = 41;
        run_req(wr, 16'h0007, 16'h7777, rd, er, lat);
        check(er == 1'b1, "R8 timeout error", 32'(er), 1);
        check(rd == 16'h0, "R8 timeout rdata", 32'(rd), 0);
        check(lat == 1 + GAP*MAXP, "R8 timeout latency", lat, 1 + GAP*MAXP);
        check(phy_ctrl == '0, "R8 control word cleared", phy_ctrl, 0);
        check(clog_n == 3 && clog[2] == 32'h0, "R8 aborted after address strobe", clog_n, 3);
        check(m_mem[7] == 16'h0, "R8 no write landed", m_mem[7], 0);
        up_dly = 3;
    endtask

    task automatic t_back_to_back();
        bit overlap_ok = 1;
        bit seen_rsp   = 0;
        logic [15:0] rd1;
        logic er1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0009; req_wdata = 16'hC3C3;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_write = 1'b0; req_addr = 16'h0009; req_wdata = 16'h0;
        while (!req_ready) begin
            @(negedge clk);
        end
        seen_rsp = rsp_valid;
        rd1 = rsp_rdata; er1 = rsp_err;
        check(seen_rsp, "R9 second request taken only in response cycle", 32'(seen_rsp), 1);
        check(er1 == 1'b0 && rd1 == 16'h0, "R9 first response intact", {rd1, 15'b0, er1}, 0);
        @(negedge clk);
        req_valid = 1'b0;
        if (req_ready) overlap_ok = 0;
        while (!rsp_valid) @(negedge clk);
        check(overlap_ok, "R9 second request accepted", 32'(overlap_ok), 1);
        check(rsp_rdata == 16'hC3C3 && !rsp_err, "R9 second read returns first write", rsp_rdata, 16'hC3C3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(16'h0005, 16'hBEEF);
        t_read(16'h0005, 16'hBEEF);
        t_write(16'h000A, 16'h1234);
        t_read(16'h000A, 16'h1234);
        t_read(16'h0005, 16'hBEEF);
        t_slow_ack();
        t_timeout(1'b1);
        t_timeout(1'b0);
        t_back_to_back();
        t_write(16'h0001, 16'h00F0);
        report();
    end

endmodule